// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps in-flight instructions in program order inside a circular buffer. The issue stage requests a slot on a valid/ready allocate stream. The slot index it receives becomes the instruction's destination tag. Execution units later report results on a tagged result bus, and they may do so in any order. The matching slot records the value, an exception flag and a branch-misprediction flag, and then marks itself done.

Retirement runs strictly from the oldest slot, and only after that slot is done. A register-writing or store slot leaves on a valid/ready commit stream. The downstream side writes the register file or releases the store to memory. An exception or a mispredicted branch is acted on only when its slot becomes the oldest. The block then discards every slot and raises a one-cycle redirect for fetch: the handler address for an exception, or the corrected target for a branch. An external interrupt line is serviced at the retirement point and takes precedence over everything else there.

Back-pressure works as follows. An allocation is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. The retirement consumer may hold `commit_ready` low for as long as it needs. The offered slot then stays on the commit outputs unchanged, unless a redirect pre-empts it. Each slot's result is written once.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and neither `commit_valid` nor `flush_valid` is asserted. `alloc_ready` is high exactly when fewer than DEPTH slots are occupied and no redirect is raised in that cycle. Accepted allocations receive tags that step by one modulo DEPTH.
- R2: A result write with `wb_valid` high marks the slot named by `wb_tag` done and captures `wb_data`, `wb_exc` and `wb_misp`. Writes may arrive in any order.
- R3: `commit_valid` is high only while the oldest slot is done and carries neither flag. The outputs then show that slot's tag, kind, destination and captured data. Kind codes are 0 for a register write, 1 for a store and 2 for a branch.
- R4: While `commit_ready` is low, the offered slot stays on the commit outputs and is not removed. At most one slot retires per cycle, and it retires on the handshake.
- R5: An allocation and a retirement may take effect in the same cycle, which leaves the occupancy unchanged.
- R6: When the oldest done slot carries the exception flag, the block raises `flush_valid` with cause 1 and `flush_pc` = HANDLER_PC, and it does not commit that slot. An exception flag on a younger slot has no effect until that slot becomes the oldest.
- R7: When the oldest done slot carries the misprediction flag, the block raises `flush_valid` with cause 2 and `flush_pc` equal to that slot's captured data. Any redirect leaves the buffer empty in the next cycle. The next allocation then receives the tag of the slot that was oldest.
- R8: While `irq` is high, the block raises `flush_valid` with cause 3 and `flush_pc` = HANDLER_PC, even if the buffer is empty. This overrides a pending commit, exception or misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Issue stage requests a slot |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_kind | input | 2 | Instruction kind: 0 register, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register number |
| alloc_tag | output | IDX_W | Tag that the next accepted allocation receives |
| wb_valid | input | 1 | Result bus carries a result |
| wb_tag | input | IDX_W | Slot that the result belongs to |
| wb_data | input | DATA_W | Result value, or the corrected target for a branch |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_misp | input | 1 | Branch was mispredicted |
| commit_valid | output | 1 | Oldest slot is offered for retirement |
| commit_ready | input | 1 | Consumer accepts the offered slot |
| commit_tag | output | IDX_W | Tag of the offered slot |
| commit_kind | output | 2 | Kind of the offered slot |
| commit_dest | output | REG_W | Destination register of the offered slot |
| commit_data | output | DATA_W | Captured result of the offered slot |
| irq | input | 1 | External interrupt request |
| flush_valid | output | 1 | Discard all slots and redirect fetch |
| flush_cause | output | 2 | 1 exception, 2 misprediction, 3 interrupt |
| flush_pc | output | DATA_W | Fetch redirect address |

## Verification
A corrupted head or tail pointer shows up at once on `alloc_tag`. It also shows up within a cycle or two as a commit of the wrong tag or as a wrong `alloc_ready` near full. A stale done or flag bit shows up the moment that slot becomes the oldest. The commit would then be early or missing, or the redirect would carry the wrong cause or address. Flush damage shows up in the cycle after a redirect, when the next allocation tag must equal the old oldest slot. For these reasons the bench compares every output against a queue model on every cycle, instead of only at the end of each scenario.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_EXC  = 2'd1,
    CAUSE_MISP = 2'd2,
    CAUSE_IRQ  = 2'd3
  } rob_cause_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W:0]   occ,
  output logic             full,
  output logic             empty
);

  // extra top bit toggles on each lap so equal indices can mean full or empty
  logic [IDX_W:0] head_q, tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      tail_q <= head_q;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign occ      = tail_q - head_q;
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[IDX_W] != tail_q[IDX_W]) &&
                    (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);

endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  input  logic              wb_misp,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_done,
  output logic              rd_exc,
  output logic              rd_misp,
  output logic [1:0]        rd_kind,
  output logic [REG_W-1:0]  rd_dest,
  output logic [DATA_W-1:0] rd_data
);

  logic [DEPTH-1:0] done_v, exc_v, misp_v;
  logic [1:0]        kind_a [DEPTH];
  logic [REG_W-1:0]  dest_a [DEPTH];
  logic [DATA_W-1:0] data_a [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              done_r, exc_r, misp_r;
    logic [1:0]        kind_r;
    logic [REG_W-1:0]  dest_r;
    logic [DATA_W-1:0] data_r;
    logic              hit_alloc, hit_wb;

    assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(g));
    assign hit_wb    = wb_en && (wb_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_r <= 1'b0;
        exc_r  <= 1'b0;
        misp_r <= 1'b0;
      end else if (hit_alloc) begin
        done_r <= 1'b0;
        exc_r  <= 1'b0;
        misp_r <= 1'b0;
      end else if (hit_wb) begin
        done_r <= 1'b1;
        exc_r  <= wb_exc;
        misp_r <= wb_misp;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        kind_r <= alloc_kind;
        dest_r <= alloc_dest;
      end
      if (hit_wb && !hit_alloc) data_r <= wb_data;
    end

    assign done_v[g] = done_r;
    assign exc_v[g]  = exc_r;
    assign misp_v[g] = misp_r;
    assign kind_a[g] = kind_r;
    assign dest_a[g] = dest_r;
    assign data_a[g] = data_r;
  end

  assign rd_done = done_v[rd_idx];
  assign rd_exc  = exc_v[rd_idx];
  assign rd_misp = misp_v[rd_idx];
  assign rd_kind = kind_a[rd_idx];
  assign rd_dest = dest_a[rd_idx];
  assign rd_data = data_a[rd_idx];

endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int                REG_W      = 5,
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] HANDLER_PC = '0
) (
  input  logic              empty,
  input  logic              head_done,
  input  logic              head_exc,
  input  logic              head_misp,
  input  logic [DATA_W-1:0] head_data,
  input  logic              irq,
  input  logic              commit_ready,
  output logic              commit_valid,
  output logic              pop,
  output logic              flush_valid,
  output logic [1:0]        flush_cause,
  output logic [DATA_W-1:0] flush_pc
);

  logic head_ok;
  assign head_ok = !empty && head_done;

  always_comb begin
    commit_valid = 1'b0;
    flush_valid  = 1'b0;
    flush_cause  = CAUSE_NONE;
    flush_pc     = '0;
    if (irq) begin
      flush_valid = 1'b1;
      flush_cause = CAUSE_IRQ;
      flush_pc    = HANDLER_PC;
    end else if (head_ok && head_exc) begin
      flush_valid = 1'b1;
      flush_cause = CAUSE_EXC;
      flush_pc    = HANDLER_PC;
    end else if (head_ok && head_misp) begin
      flush_valid = 1'b1;
      flush_cause = CAUSE_MISP;
      flush_pc    = head_data;
    end else begin
      commit_valid = head_ok;
    end
  end

  assign pop = commit_valid && commit_ready;

endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import rob_pkg::*;
#(
  parameter int                DEPTH      = 8,
  parameter int                REG_W      = 5,
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] HANDLER_PC = DATA_W'(32'h0000_0100),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  input  logic              wb_misp,
  output logic              commit_valid,
  input  logic              commit_ready,
  output logic [IDX_W-1:0]  commit_tag,
  output logic [1:0]        commit_kind,
  output logic [REG_W-1:0]  commit_dest,
  output logic [DATA_W-1:0] commit_data,
  input  logic              irq,
  output logic              flush_valid,
  output logic [1:0]        flush_cause,
  output logic [DATA_W-1:0] flush_pc
);

  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [IDX_W:0]    occ;
  logic              full, empty, push, pop, wb_en;
  logic              head_done, head_exc, head_misp;
  logic [DATA_W-1:0] head_data;

  assign alloc_ready = !full && !flush_valid;
  assign push        = alloc_valid && alloc_ready;
  assign wb_en       = wb_valid && !flush_valid;
  assign alloc_tag   = tail_idx;
  assign commit_tag  = head_idx;
  assign commit_data = head_data;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .flush    (flush_valid),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .occ      (occ),
    .full     (full),
    .empty    (empty)
  );

  rob_entries #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (push),
    .alloc_idx  (tail_idx),
    .alloc_kind (alloc_kind),
    .alloc_dest (alloc_dest),
    .wb_en      (wb_en),
    .wb_idx     (wb_tag),
    .wb_data    (wb_data),
    .wb_exc     (wb_exc),
    .wb_misp    (wb_misp),
    .rd_idx     (head_idx),
    .rd_done    (head_done),
    .rd_exc     (head_exc),
    .rd_misp    (head_misp),
    .rd_kind    (commit_kind),
    .rd_dest    (commit_dest),
    .rd_data    (head_data)
  );

  rob_retire #(.REG_W(REG_W), .DATA_W(DATA_W), .HANDLER_PC(HANDLER_PC)) u_retire (
    .empty        (empty),
    .head_done    (head_done),
    .head_exc     (head_exc),
    .head_misp    (head_misp),
    .head_data    (head_data),
    .irq          (irq),
    .commit_ready (commit_ready),
    .commit_valid (commit_valid),
    .pop          (pop),
    .flush_valid  (flush_valid),
    .flush_cause  (flush_cause),
    .flush_pc     (flush_pc)
  );

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic              commit_valid,
  input logic              commit_ready,
  input logic [IDX_W-1:0]  commit_tag,
  input logic [DATA_W-1:0] commit_data,
  input logic              flush_valid,
  input logic [1:0]        flush_cause,
  input logic              irq,
  input logic [IDX_W:0]    occ
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |-> occ < (IDX_W+1)'(DEPTH)); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> occ == '0); // R7

  AST_NO_COMMIT_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !commit_valid && !alloc_ready); // R6

  AST_COMMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && !commit_ready |=>
      flush_valid || (commit_valid && $stable(commit_tag) && $stable(commit_data))); // R4

  AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flush_valid && flush_cause == 2'd3); // R8

endmodule

bind reorder_buffer rob_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rob_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .commit_valid (commit_valid),
  .commit_ready (commit_ready),
  .commit_tag   (commit_tag),
  .commit_data  (commit_data),
  .flush_valid  (flush_valid),
  .flush_cause  (flush_cause),
  .irq          (irq),
  .occ          (occ)
);

// File: tb/test_reorder_buffer.sv
module test_reorder_buffer;
  localparam int DEPTH = 8;
  localparam int REG_W = 5;
  localparam int DATA_W = 32;
  localparam int IDX_W = 3;
  localparam logic [31:0] HPC = 32'h0000_0100;

  logic clk, rst_n;
  logic alloc_valid, alloc_ready;
  logic [1:0] alloc_kind;
  logic [REG_W-1:0] alloc_dest;
  logic [IDX_W-1:0] alloc_tag;
  logic wb_valid, wb_exc, wb_misp;
  logic [IDX_W-1:0] wb_tag;
  logic [DATA_W-1:0] wb_data;
  logic commit_valid, commit_ready;
  logic [IDX_W-1:0] commit_tag;
  logic [1:0] commit_kind;
  logic [REG_W-1:0] commit_dest;
  logic [DATA_W-1:0] commit_data;
  logic irq, flush_valid;
  logic [1:0] flush_cause;
  logic [DATA_W-1:0] flush_pc;

  reorder_buffer #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .HANDLER_PC(HPC)) i_reorder_buffer (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc), .wb_misp(wb_misp),
    .commit_valid(commit_valid), .commit_ready(commit_ready), .commit_tag(commit_tag),
    .commit_kind(commit_kind), .commit_dest(commit_dest), .commit_data(commit_data),
    .irq(irq), .flush_valid(flush_valid), .flush_cause(flush_cause), .flush_pc(flush_pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference: ordered list of live tags plus per-tag records
  int q[$];
  int nxt = 0;
  bit m_done [DEPTH];
  bit m_exc  [DEPTH];
  bit m_misp [DEPTH];
  int m_kind [DEPTH];
  int m_dest [DEPTH];
  longint m_data [DEPTH];

  int checks = 0;
  int fails = 0;
  bit sim_done = 0;
  string phase = "RST";

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!sim_done && !rst_n) begin
      chk("R1", "reset alloc_ready", alloc_ready, 1);
      chk("R1", "reset alloc_tag", alloc_tag, 0);
      chk("R1", "reset commit_valid", commit_valid, 0);
      chk("R1", "reset flush_valid", flush_valid, 0);
    end else if (!sim_done) begin
      bit e_fl, e_cv, e_ar, hd;
      int e_cause, h;
      longint e_pc;
      string freq;
      hd = q.size() > 0;
      h = hd ? q[0] : 0;
      e_fl = 0; e_cv = 0; e_cause = 0; e_pc = 0; freq = "R6";
      if (irq) begin
        e_fl = 1; e_cause = 3; e_pc = HPC; freq = "R8";
      end else if (hd && m_done[h] && m_exc[h]) begin
        e_fl = 1; e_cause = 1; e_pc = HPC; freq = "R6";
      end else if (hd && m_done[h] && m_misp[h]) begin
        e_fl = 1; e_cause = 2; e_pc = m_data[h]; freq = "R7";
      end else begin
        e_cv = hd && m_done[h];
      end
      e_ar = (q.size() < DEPTH) && !e_fl;

      chk("R1", "alloc_ready", alloc_ready, e_ar);
      chk("R1", "alloc_tag", alloc_tag, nxt);
      chk("R3", "commit_valid", commit_valid, e_cv);
      if (e_cv) begin
        chk("R3", "commit_tag", commit_tag, h);
        chk("R3", "commit_kind", commit_kind, m_kind[h]);
        chk("R3", "commit_dest", commit_dest, m_dest[h]);
        chk("R3", "commit_data", commit_data, m_data[h]);
      end
      chk(freq, "flush_valid", flush_valid, e_fl);
      if (e_fl) begin
        chk(freq, "flush_cause", flush_cause, e_cause);
        chk(freq, "flush_pc", flush_pc, e_pc);
      end

      if (e_fl) begin
        if (q.size() > 0) nxt = q[0];
        q.delete();
      end else begin
        if (e_cv && commit_ready) void'(q.pop_front());
        if (wb_valid) begin
          m_done[wb_tag] = 1;
          m_exc[wb_tag]  = wb_exc;
          m_misp[wb_tag] = wb_misp;
          m_data[wb_tag] = wb_data;
        end
        if (alloc_valid && e_ar) begin
          q.push_back(nxt);
          m_done[nxt] = 0; m_exc[nxt] = 0; m_misp[nxt] = 0;
          m_kind[nxt] = alloc_kind;
          m_dest[nxt] = alloc_dest;
          nxt = (nxt + 1) % DEPTH;
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_alloc(int kind, int dest, output int tag);
    tag = alloc_tag;
    alloc_valid = 1; alloc_kind = 2'(kind); alloc_dest = REG_W'(dest);
    cyc();
    alloc_valid = 0;
  endtask

  task automatic do_wb(int tag, int unsigned data, bit e, bit m);
    wb_valid = 1; wb_tag = IDX_W'(tag); wb_data = data; wb_exc = e; wb_misp = m;
    cyc();
    wb_valid = 0; wb_exc = 0; wb_misp = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=timeout expected=finish");
    sim_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t, a, b, c, d, prev, cur;
    int ord [8] = '{5, 2, 0, 7, 1, 3, 6, 4};
    rst_n = 0; alloc_valid = 0; alloc_kind = 0; alloc_dest = 0;
    wb_valid = 0; wb_tag = 0; wb_data = 0; wb_exc = 0; wb_misp = 0;
    commit_ready = 1; irq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();

    phase = "R1";
    for (int i = 0; i < DEPTH; i++) do_alloc(0, i + 1, t);
    alloc_valid = 1; alloc_kind = 0; alloc_dest = 5'd20;
    idle(2);
    alloc_valid = 0;

    phase = "R2";
    for (int i = 0; i < DEPTH; i++) do_wb(ord[i], 32'h1000 + ord[i], 0, 0);
    idle(3);

    phase = "R4";
    commit_ready = 0;
    do_alloc(1, 7, a);
    do_alloc(0, 9, b);
    do_wb(a, 32'hA5A5, 0, 0);
    do_wb(b, 32'h5A5A, 0, 0);
    idle(3);
    commit_ready = 1;
    idle(3);

    phase = "R5";
    do_alloc(0, 1, prev);
    for (int i = 0; i < 6; i++) begin
      cur = alloc_tag;
      alloc_valid = 1; alloc_kind = 0; alloc_dest = REG_W'(i + 2);
      wb_valid = 1; wb_tag = IDX_W'(prev); wb_data = 32'h2000 + i;
      cyc();
      alloc_valid = 0; wb_valid = 0;
      prev = cur;
    end
    do_wb(prev, 32'h2FFF, 0, 0);
    idle(3);

    phase = "R6";
    do_alloc(0, 3, a);
    do_alloc(0, 4, b);
    do_alloc(0, 5, c);
    do_wb(c, 32'hDEAD, 1, 0);
    idle(2);
    do_wb(a, 32'h11, 0, 0);
    do_wb(b, 32'h22, 0, 0);
    idle(3);
    do_alloc(0, 6, d);
    chk("R6", "tag after exception flush", d, c);
    do_wb(d, 32'h33, 0, 0);
    idle(2);

    phase = "R7";
    do_alloc(2, 0, a);
    do_alloc(0, 8, b);
    do_wb(b, 32'h44, 0, 0);
    do_wb(a, 32'h0000_0400, 0, 1);
    idle(2);
    do_alloc(0, 9, d);
    chk("R7", "tag after mispredict flush", d, a);
    do_wb(d, 32'h55, 0, 0);
    do_alloc(2, 0, c);
    do_wb(c, 32'h0000_0800, 0, 0);
    idle(3);

    phase = "R8";
    do_alloc(0, 10, a);
    do_wb(a, 32'h66, 1, 0);
    irq = 1; cyc(); irq = 0;
    idle(2);
    irq = 1; cyc(); irq = 0;
    idle(1);
    do_alloc(1, 11, b);
    do_wb(b, 32'h77, 0, 0);
    irq = 1; cyc(); irq = 0;
    idle(3);

    sim_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule